// File: doc/BRIEF.md
# Direct Stream Digital Bitstream Receiver

This block takes a two-channel one-bit audio bitstream (channel A and channel B) together with its bit clock and recovers one sample per channel for each bit period. It works in three decoding styles. In plain mode one bit arrives per bit-clock rising edge. In phase-modulated mode every bit is followed by its complement; the complement either comes on a second rising edge of a double-rate clock or on the falling edge of a single-rate clock. A mismatched complement raises a framing flag. The bit clock is oversampled by the system clock `clk`. Each half period of the bit clock must last at least two `clk` cycles. In master mode the block drives its own bit clock at the selected stream rate.

Two monitors watch the recovered bits. A density monitor keeps a sliding 28-bit window per channel and flags a channel whose ones-minus-zeros balance goes past a programmable limit; the data still passes through unchanged. A stuck monitor replaces a channel that holds one value for too long with an alternating idle pattern until the stream moves again. All four status flags are sticky, are cleared by writing 1, and raise `irq`.

The sample interface is valid/ready. `out_valid` rises one cycle after a bit completes. It stays high, with stable data, until `out_ready` is seen high. No back-pressure reaches the bit stream. If a new bit completes while a sample is still waiting, the newer sample replaces it. Configuration is latched only while `if_pwrdn` is high. Reception starts only on a rising edge of `rx_enable` that comes after power-down has been released.

Top module: `dsd_stream_rx`

## Requirements
- R1: `cfg_master`, `cfg_rate128`, `cfg_pm` and `cfg_pm_clk128` are captured while `if_pwrdn` is 1. Changes made to them while `if_pwrdn` is 0 have no effect.
- R2: Reception runs only after a 0-to-1 transition of `rx_enable` made while `if_pwrdn` is 0. An `rx_enable` already high when power-down is released starts nothing. Raising `if_pwrdn` stops reception.
- R3: In plain mode, each rising edge of the bit clock delivers one sample: `out_a` is `din_a` and `out_b` is `din_b` as sampled at that edge.
- R4: In phase-modulated mode with `cfg_pm_clk128`=1, each pair of rising edges yields one sample, equal to the value at the first edge. If the second-edge value is not the complement of the first on either channel, status bit 3 (framing) is set.
- R5: In phase-modulated mode with `cfg_pm_clk128`=0, the value at the rising edge is the sample. The value at the following falling edge must be its complement, otherwise status bit 3 is set.
- R6: Phase modulation is allowed only at the 64-times rate. With `cfg_rate128`=1, `cfg_pm` is ignored and plain decoding applies.
- R7: In master mode while receiving, `bclk_out` toggles every HALF64 `clk` cycles at the 64-times rate and every HALF64/2 cycles at the 128-times rate. Otherwise `bclk_out` is 0.
- R8: With `ovm_det_en`=1, after the first 28 bits, a channel whose last 28 bits hold N ones with |2N-28| > `ovm_limit` sets status bit 0 (A) or bit 1 (B). Output data is not altered. With `ovm_det_en`=0 these bits never set.
- R9: With `stuck_det_en`=1, the bit that completes STUCK_LEN identical bits on a channel sets status bit 2. From the next bit on, that channel outputs the idle pattern 1,0,1,0,…, starting with 1.
- R10: A muted channel is examined in consecutive 16-bit windows, starting with its first muted bit. At the end of a window that contains a change of input value, the mute is lifted and the next bit passes raw.
- R11: Status bits are sticky. Writing 1 to a bit of `status_clr` clears that bit; a set in the same cycle wins. `irq` is 1 exactly when any status bit is 1.
- R12: While `out_valid`=1 and `out_ready`=0, `out_valid` and the data stay unchanged unless a newer bit completes, in which case the data is replaced. After a cycle with `out_ready`=1 and no new bit, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1: block generates the bit clock |
| cfg_rate128 | input | 1 | 1: 128-times stream rate, 0: 64-times |
| cfg_pm | input | 1 | Phase-modulated input |
| cfg_pm_clk128 | input | 1 | Phase modulation with double-rate clock |
| if_pwrdn | input | 1 | Interface power-down; configuration is latched while high |
| rx_enable | input | 1 | Reception enable (rising edge after release) |
| ovm_det_en | input | 1 | Density monitor enable |
| stuck_det_en | input | 1 | Stuck monitor enable |
| ovm_limit | input | LIM_W | Allowed ones-minus-zeros magnitude |
| bclk_in | input | 1 | External bit clock (slave mode) |
| din_a | input | 1 | Channel A bitstream |
| din_b | input | 1 | Channel B bitstream |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| out_valid | output | 1 | Sample valid |
| out_ready | input | 1 | Sample accepted |
| out_a | output | 1 | Channel A sample |
| out_b | output | 1 | Channel B sample |
| status | output | 4 | Sticky flags: [0] density A, [1] density B, [2] stuck, [3] framing |
| status_clr | input | 4 | Write-1-to-clear for `status` |
| irq | output | 1 | OR of all status bits |

## Verification
The hardest condition to reach is the end of a stuck episode. The stream must first hold one value for STUCK_LEN bits and trigger the mute. It must then change at a known point, and only the window boundary 16 bits after the mute began may release the channel. The bench builds the design with a short STUCK_LEN so it can hold channel A high long enough to mute it, then switch it to alternation. It computes, bit by bit, which outputs are raw and which follow the idle phase. The density limit is reached from both sides with periodic patterns whose windows hold exactly 24, 25, 4 or 0 ones.

// File: rtl/dsdrx_pkg.sv
package dsdrx_pkg;
  typedef struct packed {
    logic master;
    logic rate128;
    logic pm;
    logic pm_clk128;
  } dsdrx_cfg_t;

  localparam int unsigned ST_OVM_A = 0;
  localparam int unsigned ST_OVM_B = 1;
  localparam int unsigned ST_STUCK = 2;
  localparam int unsigned ST_FRAME = 3;
  localparam int unsigned ST_W     = 4;
  localparam int unsigned NCH      = 2;
endpackage

// File: rtl/dsdrx_ctrl.sv
module dsdrx_ctrl
  import dsdrx_pkg::*;
#(
  parameter int unsigned HALF64 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  dsdrx_cfg_t cfg_in,
  input  logic       if_pwrdn,
  input  logic       rx_enable,
  output dsdrx_cfg_t cfg_q,
  output logic       running,
  output logic       gen_clk
);
  localparam int unsigned HALF128 = (HALF64 / 2 < 1) ? 1 : HALF64 / 2;
  localparam int unsigned GW      = (HALF64 < 2) ? 1 : $clog2(HALF64);

  logic          en_q;
  logic [GW-1:0] gcnt;
  logic [GW-1:0] half_m1;

  assign half_m1 = cfg_q.rate128 ? GW'(HALF128 - 1) : GW'(HALF64 - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      en_q    <= 1'b0;
      running <= 1'b0;
    end else begin
      en_q <= rx_enable;
      if (if_pwrdn) cfg_q <= cfg_in;
      if (if_pwrdn || !rx_enable) running <= 1'b0;
      else if (!en_q)             running <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt    <= '0;
      gen_clk <= 1'b0;
    end else if (!running || !cfg_q.master) begin
      gcnt    <= '0;
      gen_clk <= 1'b0;
    end else if (gcnt >= half_m1) begin
      gcnt    <= '0;
      gen_clk <= ~gen_clk;
    end else begin
      gcnt <= gcnt + 1'b1;
    end
  end

  a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !if_pwrdn |=> $stable(cfg_q));
  a_r2_pwrdn_stops: assert property (@(posedge clk) disable iff (!rst_n)
    if_pwrdn |=> !running);
  a_r2_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(rx_enable) && !$past(en_q));
  a_r7_quiet_slave: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.master || !running) |=> !gen_clk);
endmodule

// File: rtl/dsdrx_decode.sv
module dsdrx_decode
  import dsdrx_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           running,
  input  logic           pm_on,
  input  logic           pm_clk128,
  input  logic           bclk,
  input  logic [NCH-1:0] din,
  output logic           bit_stb,
  output logic [NCH-1:0] bit_val,
  output logic           frame_err
);
  logic           bclk_q;
  logic           phase;
  logic [NCH-1:0] hold;
  logic           rise, fall, check_edge;

  assign rise       = bclk & ~bclk_q;
  assign fall       = ~bclk & bclk_q;
  assign check_edge = pm_clk128 ? rise : fall;

  always_comb begin
    bit_stb   = 1'b0;
    bit_val   = din;
    frame_err = 1'b0;
    if (running) begin
      if (!pm_on) begin
        bit_stb = rise;
      end else if (phase && check_edge) begin
        bit_stb   = 1'b1;
        bit_val   = hold;
        frame_err = (din != ~hold);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      phase  <= 1'b0;
      hold   <= '0;
    end else begin
      bclk_q <= bclk;
      if (!running || !pm_on) begin
        phase <= 1'b0;
      end else if (phase && check_edge) begin
        phase <= 1'b0;
      end else if (!phase && rise) begin
        phase <= 1'b1;
        hold  <= din;
      end
    end
  end

  a_r3_stb_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> (bclk != bclk_q));
  a_r4_frame_only_pm: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (pm_on && bit_stb));
endmodule

// File: rtl/dsdrx_ovm.sv
module dsdrx_ovm #(
  parameter int unsigned WIN   = 28,
  parameter int unsigned LIM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             stb,
  input  logic             bit_in,
  input  logic [LIM_W-1:0] limit,
  output logic             over
);
  localparam int unsigned CW = $clog2(WIN + 1);

  logic [WIN-1:0] win;
  logic [CW-1:0]  ones, fill, ones_nx, fill_nx;
  logic           full;
  int             twice;

  assign full    = (fill == CW'(WIN));
  assign ones_nx = ones + CW'(bit_in) - CW'(full & win[WIN-1]);
  assign fill_nx = full ? fill : fill + 1'b1;

  always_comb begin
    twice = 2 * int'(ones_nx);
    over  = stb && (fill_nx == CW'(WIN)) &&
            ((twice > int'(WIN) + int'(limit)) || (twice + int'(limit) < int'(WIN)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win  <= '0;
      ones <= '0;
      fill <= '0;
    end else if (!running) begin
      win  <= '0;
      ones <= '0;
      fill <= '0;
    end else if (stb) begin
      win  <= {win[WIN-2:0], bit_in};
      ones <= ones_nx;
      fill <= fill_nx;
    end
  end

  a_r8_ones_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= fill);
  a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(WIN));
endmodule

// File: rtl/dsdrx_stuck.sv
module dsdrx_stuck #(
  parameter int unsigned STUCK_LEN = 256,
  parameter int unsigned REL_LEN   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic running,
  input  logic en,
  input  logic stb,
  input  logic bit_in,
  output logic muted,
  output logic idle,
  output logic stuck_set
);
  localparam int unsigned RW = $clog2(STUCK_LEN + 1);
  localparam int unsigned QW = $clog2(REL_LEN + 1);

  logic          prev, saw, trig, moved;
  logic [RW-1:0] run, run_nx;
  logic [QW-1:0] rel_cnt;

  assign moved  = (bit_in != prev);
  assign run_nx = (run == '0 || moved) ? RW'(1) :
                  (run == RW'(STUCK_LEN)) ? run : run + 1'b1;
  assign trig      = en && (run_nx == RW'(STUCK_LEN));
  assign stuck_set = running && stb && !muted && trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0; run <= '0; muted <= 1'b0; idle <= 1'b1;
      saw <= 1'b0; rel_cnt <= '0;
    end else if (!running) begin
      prev <= 1'b0; run <= '0; muted <= 1'b0; idle <= 1'b1;
      saw <= 1'b0; rel_cnt <= '0;
    end else if (!en) begin
      muted <= 1'b0;
      if (stb) begin
        prev <= bit_in;
        run  <= run_nx;
      end
    end else if (stb) begin
      prev <= bit_in;
      run  <= run_nx;
      if (!muted) begin
        if (trig) begin
          muted   <= 1'b1;
          idle    <= 1'b1;
          rel_cnt <= '0;
          saw     <= 1'b0;
        end
      end else begin
        idle <= ~idle;
        if (rel_cnt == QW'(REL_LEN - 1)) begin
          rel_cnt <= '0;
          saw     <= 1'b0;
          if (saw || moved) muted <= 1'b0;
        end else begin
          rel_cnt <= rel_cnt + 1'b1;
          saw     <= saw | moved;
        end
      end
    end
  end

  a_r9_run_sat: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(STUCK_LEN));
  a_r9_mute_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !muted);
  a_r10_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rel_cnt < QW'(REL_LEN));
endmodule

// File: rtl/dsd_stream_rx.sv
module dsd_stream_rx
  import dsdrx_pkg::*;
#(
  parameter int unsigned WIN       = 28,
  parameter int unsigned LIM_W     = 5,
  parameter int unsigned STUCK_LEN = 256,
  parameter int unsigned REL_LEN   = 16,
  parameter int unsigned HALF64    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_rate128,
  input  logic             cfg_pm,
  input  logic             cfg_pm_clk128,
  input  logic             if_pwrdn,
  input  logic             rx_enable,
  input  logic             ovm_det_en,
  input  logic             stuck_det_en,
  input  logic [LIM_W-1:0] ovm_limit,
  input  logic             bclk_in,
  input  logic             din_a,
  input  logic             din_b,
  output logic             bclk_out,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_a,
  output logic             out_b,
  output logic [ST_W-1:0]  status,
  input  logic [ST_W-1:0]  status_clr,
  output logic             irq
);
  dsdrx_cfg_t     cfg_in, cfg_q;
  logic           running, gen_clk, bclk_sel, pm_on;
  logic           bit_stb, frame_err;
  logic [NCH-1:0] bit_val, ovm_hit, mute, idle, stk_set, shown;
  logic [ST_W-1:0] set_vec;

  assign cfg_in   = '{master: cfg_master, rate128: cfg_rate128,
                      pm: cfg_pm, pm_clk128: cfg_pm_clk128};
  assign bclk_sel = cfg_q.master ? gen_clk : bclk_in;
  assign bclk_out = gen_clk;
  assign pm_on    = cfg_q.pm & ~cfg_q.rate128;

  dsdrx_ctrl #(.HALF64(HALF64)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .if_pwrdn(if_pwrdn),
    .rx_enable(rx_enable), .cfg_q(cfg_q), .running(running), .gen_clk(gen_clk)
  );

  dsdrx_decode u_dec (
    .clk(clk), .rst_n(rst_n), .running(running), .pm_on(pm_on),
    .pm_clk128(cfg_q.pm_clk128), .bclk(bclk_sel), .din({din_b, din_a}),
    .bit_stb(bit_stb), .bit_val(bit_val), .frame_err(frame_err)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dsdrx_ovm #(.WIN(WIN), .LIM_W(LIM_W)) u_ovm (
      .clk(clk), .rst_n(rst_n), .running(running), .stb(bit_stb),
      .bit_in(bit_val[g]), .limit(ovm_limit), .over(ovm_hit[g])
    );
    dsdrx_stuck #(.STUCK_LEN(STUCK_LEN), .REL_LEN(REL_LEN)) u_stuck (
      .clk(clk), .rst_n(rst_n), .running(running), .en(stuck_det_en),
      .stb(bit_stb), .bit_in(bit_val[g]), .muted(mute[g]), .idle(idle[g]),
      .stuck_set(stk_set[g])
    );
    assign shown[g] = mute[g] ? idle[g] : bit_val[g];
  end

  always_comb begin
    set_vec           = '0;
    set_vec[ST_OVM_A] = ovm_det_en & ovm_hit[0];
    set_vec[ST_OVM_B] = ovm_det_en & ovm_hit[1];
    set_vec[ST_STUCK] = |stk_set;
    set_vec[ST_FRAME] = frame_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~status_clr) | set_vec;
  end
  assign irq = |status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_a     <= 1'b0;
      out_b     <= 1'b0;
    end else if (bit_stb) begin
      out_valid <= 1'b1;
      out_a     <= shown[0];
      out_b     <= shown[1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !bit_stb) |=> (out_valid && $stable({out_a, out_b})));
  a_r12_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !bit_stb) |=> !out_valid);
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status) & ~$past(status_clr) & ~status) == '0));
  a_r8_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && mute == '0) |=> ({out_b, out_a} == $past(bit_val)));
endmodule

// File: tb/dsd_stream_rx_bench.sv
module dsd_stream_rx_bench;
  localparam int STK = 16;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_master = 0, cfg_rate128 = 0, cfg_pm = 0, cfg_pm_clk128 = 0;
  logic if_pwrdn = 1, rx_enable = 0, ovm_det_en = 0, stuck_det_en = 0;
  logic [4:0] ovm_limit = 5'd20;
  logic bclk_in = 0, din_a = 0, din_b = 0, out_ready = 1;
  logic bclk_out, out_valid, out_a, out_b, irq;
  logic [3:0] status, status_clr = '0;

  int tests = 0, fails = 0, ncap = 0, cycles = 0;
  logic cap_a [0:511];
  logic cap_b [0:511];

  always #4 clk = ~clk;

  dsd_stream_rx #(.STUCK_LEN(STK), .HALF64(HALF)) u_dsd_stream_rx (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_rate128(cfg_rate128),
    .cfg_pm(cfg_pm), .cfg_pm_clk128(cfg_pm_clk128), .if_pwrdn(if_pwrdn),
    .rx_enable(rx_enable), .ovm_det_en(ovm_det_en), .stuck_det_en(stuck_det_en),
    .ovm_limit(ovm_limit), .bclk_in(bclk_in), .din_a(din_a), .din_b(din_b),
    .bclk_out(bclk_out), .out_valid(out_valid), .out_ready(out_ready),
    .out_a(out_a), .out_b(out_b), .status(status), .status_clr(status_clr), .irq(irq)
  );

  always @(negedge clk) begin
    cycles++;
    if (out_valid && out_ready && ncap < 512) begin
      cap_a[ncap] = out_a;
      cap_b[ncap] = out_b;
      ncap++;
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input bit m, r128, pm, pmc, oe, se);
    @(negedge clk);
    rx_enable = 0; if_pwrdn = 1;
    cfg_master = m; cfg_rate128 = r128; cfg_pm = pm; cfg_pm_clk128 = pmc;
    ovm_det_en = oe; stuck_det_en = se; bclk_in = 0;
    waitn(2);
    status_clr = 4'hF; waitn(1); status_clr = 4'h0;
    if_pwrdn = 0; waitn(1);
    rx_enable = 1; waitn(2);
    ncap = 0;
  endtask

  task automatic send_norm(input bit a, input bit b);
    din_a = a; din_b = b; bclk_in = 1; waitn(2);
    bclk_in = 0; waitn(2);
  endtask

  task automatic send_pm_fast(input bit a, input bit b, input bit bad);
    send_norm(a, b);
    send_norm(~a ^ bad, ~b);
  endtask

  task automatic send_pm_slow(input bit a, input bit b, input bit bad);
    din_a = a; din_b = b; bclk_in = 1; waitn(2);
    din_a = ~a ^ bad; din_b = ~b; bclk_in = 0; waitn(2);
  endtask

  function automatic bit pat_a(input int i);
    return bit'(i[0]);
  endfunction
  function automatic bit pat_b(input int i);
    return bit'(i[1] ^ i[2]);
  endfunction

  initial begin
    waitn(3);
    rst_n = 1;
    waitn(1);
    // Reset state: R11, R12, R7
    chk(out_valid == 0, "R12 reset valid", int'(out_valid), 0);
    chk(status == 0 && irq == 0, "R11 reset status", int'(status), 0);
    chk(bclk_out == 0, "R7 reset bclk_out", int'(bclk_out), 0);

    // R2: enable before release does nothing
    rx_enable = 1; waitn(2);
    for (int i = 0; i < 4; i++) send_norm(1, 1);
    chk(ncap == 0, "R2 enable while powered down", ncap, 0);
    if_pwrdn = 0; waitn(2);
    for (int i = 0; i < 4; i++) send_norm(1, 0);
    chk(ncap == 0, "R2 enable held across release", ncap, 0);
    rx_enable = 0; waitn(2); rx_enable = 1; waitn(2);
    for (int i = 0; i < 4; i++) send_norm(0, 1);
    waitn(2);
    chk(ncap == 4, "R2 enable after release", ncap, 4);
    if_pwrdn = 1; waitn(2); ncap = 0;
    for (int i = 0; i < 4; i++) send_norm(1, 1);
    chk(ncap == 0, "R2 power-down stops reception", ncap, 0);

    // R3: plain mode sweep
    setup(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) send_norm(pat_a(i), pat_b(i));
    waitn(2);
    chk(ncap == 16, "R3 sample count", ncap, 16);
    for (int i = 0; i < 16; i++)
      chk(cap_a[i] == pat_a(i) && cap_b[i] == pat_b(i), "R3 data",
          int'({cap_b[i], cap_a[i]}), int'({pat_b(i), pat_a(i)}));

    // R1: config changes while running are ignored
    cfg_pm = 1; cfg_master = 1; waitn(2); ncap = 0;
    for (int i = 0; i < 8; i++) send_norm(pat_b(i), pat_a(i));
    waitn(2);
    chk(ncap == 8, "R1 still plain decoding", ncap, 8);
    chk(bclk_out == 0, "R1 master change ignored", int'(bclk_out), 0);

    // R4: phase modulation, double-rate clock
    setup(0, 0, 1, 1, 0, 0);
    for (int i = 0; i < 8; i++) send_pm_fast(pat_a(i), pat_b(i), 0);
    waitn(2);
    chk(ncap == 8, "R4 sample count", ncap, 8);
    for (int i = 0; i < 8; i++)
      chk(cap_a[i] == pat_a(i) && cap_b[i] == pat_b(i), "R4 data",
          int'({cap_b[i], cap_a[i]}), int'({pat_b(i), pat_a(i)}));
    chk(status[3] == 0, "R4 no framing error", int'(status[3]), 0);
    send_pm_fast(1, 0, 1); waitn(2);
    chk(status[3] == 1 && irq == 1, "R4 framing error", int'(status), 8);

    // R5: phase modulation, single-rate clock
    setup(0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 8; i++) send_pm_slow(pat_b(i), pat_a(i), 0);
    waitn(2);
    chk(ncap == 8, "R5 sample count", ncap, 8);
    for (int i = 0; i < 8; i++)
      chk(cap_a[i] == pat_b(i) && cap_b[i] == pat_a(i), "R5 data",
          int'({cap_b[i], cap_a[i]}), int'({pat_a(i), pat_b(i)}));
    chk(status[3] == 0, "R5 no framing error", int'(status[3]), 0);
    send_pm_slow(0, 1, 1); waitn(2);
    chk(status[3] == 1, "R5 framing error", int'(status[3]), 1);

    // R6: phase modulation ignored at 128 rate
    setup(0, 1, 1, 1, 0, 0);
    for (int i = 0; i < 8; i++) send_norm(pat_a(i), pat_b(i));
    waitn(2);
    chk(ncap == 8, "R6 plain decoding at 128", ncap, 8);
    chk(cap_a[3] == pat_a(3) && cap_b[3] == pat_b(3), "R6 data",
        int'({cap_b[3], cap_a[3]}), int'({pat_b(3), pat_a(3)}));

    // R7: generated clock period
    for (int r = 0; r < 2; r++) begin
      int t0, t1;
      logic pv;
      setup(1, bit'(r), 0, 0, 0, 0);
      pv = bclk_out;
      while (bclk_out == pv) @(negedge clk);
      t0 = cycles; pv = bclk_out;
      while (bclk_out == pv) @(negedge clk);
      t1 = cycles;
      chk(t1 - t0 == (r == 0 ? HALF : HALF / 2), "R7 half period", t1 - t0,
          r == 0 ? HALF : HALF / 2);
    end

    // R8: density monitor
    setup(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 28; i++) send_norm(1, bit'(i[0]));
    waitn(2);
    chk(status[0] == 1 && status[1] == 0, "R8 A flagged, B balanced", int'(status), 1);
    chk(cap_a[27] == 1 && cap_a[0] == 1, "R8 data unchanged", int'(cap_a[27]), 1);
    setup(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 56; i++) send_norm(bit'(i % 7 != 3), bit'(i % 7 == 3));
    waitn(2);
    chk(status[1:0] == 0, "R8 24 and 4 ones at limit", int'(status[1:0]), 0);
    setup(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 56; i++) send_norm(bit'(i % 28 > 2), 0);
    waitn(2);
    chk(status[1:0] == 2'b11, "R8 25 ones and 0 ones", int'(status[1:0]), 3);
    setup(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) send_norm(1, 0);
    waitn(2);
    chk(status == 0, "R8 monitor disabled", int'(status), 0);

    // R9, R10: stuck mute and release
    setup(0, 0, 0, 0, 0, 1);
    for (int k = 1; k <= 40; k++)
      send_norm(k <= 20 ? 1'b1 : bit'((k - 21) % 2), bit'(k % 2));
    waitn(2);
    chk(ncap == 40, "R9 sample count", ncap, 40);
    for (int k = 1; k <= 40; k++) begin
      bit ea;
      if (k <= STK) ea = 1;
      else if (k <= STK + 16) ea = bit'((k - STK - 1) % 2 == 0);
      else ea = bit'((k - 21) % 2);
      chk(cap_a[k-1] == ea, k <= STK + 16 ? "R9 A output" : "R10 A released",
          int'(cap_a[k-1]), int'(ea));
      chk(cap_b[k-1] == bit'(k % 2), "R9 B untouched", int'(cap_b[k-1]), k % 2);
    end
    chk(status == 4'b0100, "R9 stuck flag", int'(status), 4);
    setup(0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 40; k++) send_norm(0, 1);
    waitn(2);
    chk(cap_a[39] == 0 && cap_b[39] == 1 && status == 0, "R9 disabled passes raw",
        int'(status), 0);

    // R11: write-1-to-clear
    setup(0, 0, 0, 0, 0, 1);
    for (int k = 0; k < STK; k++) send_norm(1, 1);
    cfg_pm = 0;
    waitn(2);
    chk(status[2] == 1, "R11 stuck set", int'(status), 4);
    status_clr = 4'b1011; waitn(1); status_clr = 0; waitn(1);
    chk(status == 4'b0100 && irq == 1, "R11 other clears ignored", int'(status), 4);
    status_clr = 4'b0100; waitn(1); status_clr = 0; waitn(1);
    chk(status == 0 && irq == 0, "R11 cleared", int'(status), 0);

    // R12: back-pressure and overwrite
    setup(0, 0, 0, 0, 0, 0);
    out_ready = 0;
    send_norm(1, 0);
    send_norm(0, 1);
    waitn(3);
    chk(out_valid == 1 && out_a == 0 && out_b == 1, "R12 newest held",
        int'({out_valid, out_b, out_a}), 6);
    waitn(4);
    chk(out_valid == 1 && out_a == 0 && out_b == 1, "R12 stable while stalled",
        int'({out_valid, out_b, out_a}), 6);
    out_ready = 1; waitn(2);
    chk(out_valid == 0, "R12 released after accept", int'(out_valid), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule